// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns the operands of a load or store into the address that goes to memory, together with the new value of any base register the access is meant to update. A small load/store unit feeds it a mode code, a base register, an index register, a modifier register, a global-pointer value, an immediate and an access-size code. The block returns the effective address, a writeback value with its enable, and a cancel flag raised when the predicate guarding the access rejects it.

Seven addressing forms share one datapath: base plus a size-scaled signed offset, an unsigned immediate plus a left-shifted index, absolute-set (the immediate is both the address and the value written to a destination register), post-increment by the modifier register, post-increment by a size-scaled signed immediate, a bit-reversed form that updates like the register post-increment, and a global-pointer form with a size-scaled unsigned offset. Every sum wraps modulo 2^32, no alignment check is made, and by default the outputs are registered one cycle after the inputs.

Top module: `lsu_ag_top`

## Requirements
- R1: While rst_n is low the outputs ea_o, wb_val_o, wb_en_o and cancel_o are all zero.
- R2: Mode code 0 (base offset): ea_o = base_i + (imm_i[10:0] sign-extended, shifted left by size_i); wb_en_o = 0 and wb_val_o = base_i.
- R3: Mode code 1 (scaled index): ea_o = imm_i[5:0] zero-extended + (index_i shifted left by shamt_i); size_i has no effect; wb_en_o = 0 and wb_val_o = base_i.
- R4: Mode code 2 (absolute-set): ea_o = imm_i, wb_val_o = imm_i and wb_en_o = 1 unless cancelled.
- R5: Mode code 3 (post-increment by register): ea_o = base_i, wb_val_o = base_i + mod_i, wb_en_o = 1 unless cancelled.
- R6: Mode code 4 (post-increment by immediate): ea_o = base_i, wb_val_o = base_i + (imm_i[3:0] sign-extended, shifted left by size_i), wb_en_o = 1 unless cancelled.
- R7: Mode code 5 (bit-reversed): ea_o[31:16] = base_i[31:16] and ea_o[k] = base_i[15-k] for k in 0..15; wb_val_o = base_i + mod_i, wb_en_o = 1 unless cancelled.
- R8: Mode code 6 (global pointer): ea_o = gp_i + (imm_i[15:0] zero-extended, shifted left by size_i); wb_en_o = 0 and wb_val_o = base_i.
- R9: With pred_en_i = 1 the access proceeds only when pred_i[0] differs from pred_neg_i; otherwise cancel_o = 1 and wb_en_o = 0 while ea_o and wb_val_o keep their mode values. With pred_en_i = 0 cancel_o is 0. pred_i[7:1] has no effect.
- R10: All additions wrap modulo 2^32 with no carry out and no error indication.
- R11: Mode code 7 is reserved: ea_o = base_i, wb_val_o = base_i, wb_en_o = 0.
- R12: With the default REG_OUT = 1 the outputs reflect the inputs sampled at the previous rising clock edge and stay unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Addressing mode code |
| size_i | input | 2 | Access size as log2 bytes (0 byte .. 3 double) |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| mod_i | input | 32 | Modifier register value |
| gp_i | input | 32 | Global-pointer register value |
| imm_i | input | 32 | Immediate; the mode picks which low bits are used |
| shamt_i | input | 2 | Index shift amount for the scaled-index mode |
| pred_en_i | input | 1 | Access is predicated |
| pred_neg_i | input | 1 | Predicate is the false form |
| pred_i | input | 8 | Predicate register; bit 0 decides |
| ea_o | output | 32 | Effective address |
| wb_val_o | output | 32 | Value for the base or destination register |
| wb_en_o | output | 1 | Writeback enable |
| cancel_o | output | 1 | Access cancelled by its predicate |

## Verification
The sweep drives every mode code under every size code, several operand patterns and all four predicate combinations, and compares against an arithmetic model. The corners it chases are offset sign bits at the top of each immediate field (a zero-extending design would step forward instead of back), size scaling skipped in the index mode but applied elsewhere (a design sharing one shifter would scale the index immediate), post-increment returning the updated base as the address, a bit reversal that spills into the upper half, a cancelled access that still asserts its writeback, and sums that cross 2^32. A check between clock edges catches outputs that follow the inputs combinationally.

// File: rtl/lsu_ag_pkg.sv
package lsu_ag_pkg;
   typedef enum logic [2:0] {
      AG_BASE_OFF = 3'd0,
      AG_IDX      = 3'd1,
      AG_ABS_SET  = 3'd2,
      AG_POST_REG = 3'd3,
      AG_POST_IMM = 3'd4,
      AG_BREV     = 3'd5,
      AG_GP       = 3'd6,
      AG_RSVD     = 3'd7
   } ag_mode_e;

   typedef struct packed {
      logic [31:0] ea;
      logic [31:0] wb_val;
      logic        wb_en;
      logic        cancel;
   } ag_res_t;
endpackage

// File: rtl/lsu_ag_immx.sv
// Extract a narrow immediate field, extend it, then scale it.
module lsu_ag_immx #(
   parameter int AW     = 32,
   parameter int FW     = 11,
   parameter bit SIGNED = 1'b1
) (
   input  logic [AW-1:0] imm_i,
   input  logic [1:0]    scale_i,
   output logic [AW-1:0] val_o
);
   localparam int PADW = AW - FW;

   initial begin : p_chk
      if (FW < 1 || FW >= AW) $fatal(1, "lsu_ag_immx: field width out of range");
   end

   logic [AW-1:0] ext;

   generate
      if (SIGNED) begin : g_sext
         assign ext = {{PADW{imm_i[FW-1]}}, imm_i[FW-1:0]};
      end else begin : g_zext
         assign ext = {{PADW{1'b0}}, imm_i[FW-1:0]};
      end
   endgenerate

   assign val_o = ext << scale_i;
endmodule

// File: rtl/lsu_ag_brev.sv
// Reverse the low RW bits, pass the rest through.
module lsu_ag_brev #(
   parameter int AW = 32,
   parameter int RW = 16
) (
   input  logic [AW-1:0] in_i,
   output logic [AW-1:0] out_o
);
   initial begin : p_chk
      if (RW < 2 || RW > AW) $fatal(1, "lsu_ag_brev: reverse width out of range");
   end

   generate
      for (genvar k = 0; k < RW; k++) begin : g_rev
         assign out_o[k] = in_i[RW-1-k];
      end
      if (RW < AW) begin : g_hi
         assign out_o[AW-1:RW] = in_i[AW-1:RW];
      end
   endgenerate
endmodule

// File: rtl/lsu_ag_core.sv
// Combinational address and writeback computation.
module lsu_ag_core
   import lsu_ag_pkg::*;
#(
   parameter int AW     = 32,
   parameter int PW     = 8,
   parameter int OFF_W  = 11,
   parameter int IDX_W  = 6,
   parameter int INC_W  = 4,
   parameter int GP_W   = 16,
   parameter int REV_W  = 16
) (
   input  logic [2:0]    mode_i,
   input  logic [1:0]    size_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] index_i,
   input  logic [AW-1:0] mod_i,
   input  logic [AW-1:0] gp_i,
   input  logic [AW-1:0] imm_i,
   input  logic [1:0]    shamt_i,
   input  logic          pred_en_i,
   input  logic          pred_neg_i,
   input  logic [PW-1:0] pred_i,
   output logic [AW-1:0] ea_o,
   output logic [AW-1:0] wb_val_o,
   output logic          wb_en_o,
   output logic          cancel_o
);
   initial begin : p_chk
      if (PW < 1) $fatal(1, "lsu_ag_core: predicate width must be positive");
   end

   logic [AW-1:0] off_v, idx_v, inc_v, gp_v, brev_v;
   logic [AW-1:0] ea_c, wbv_c;
   logic          upd_c, go_c;
   ag_mode_e      mode_e;

   assign mode_e = ag_mode_e'(mode_i);

   lsu_ag_immx #(.AW(AW), .FW(OFF_W), .SIGNED(1'b1)) u_off (
      .imm_i(imm_i), .scale_i(size_i), .val_o(off_v));
   lsu_ag_immx #(.AW(AW), .FW(IDX_W), .SIGNED(1'b0)) u_idx (
      .imm_i(imm_i), .scale_i(2'd0), .val_o(idx_v));
   lsu_ag_immx #(.AW(AW), .FW(INC_W), .SIGNED(1'b1)) u_inc (
      .imm_i(imm_i), .scale_i(size_i), .val_o(inc_v));
   lsu_ag_immx #(.AW(AW), .FW(GP_W), .SIGNED(1'b0)) u_gp (
      .imm_i(imm_i), .scale_i(size_i), .val_o(gp_v));
   lsu_ag_brev #(.AW(AW), .RW(REV_W)) u_brev (
      .in_i(base_i), .out_o(brev_v));

   always_comb begin
      ea_c  = base_i;
      wbv_c = base_i;
      upd_c = 1'b0;
      unique case (mode_e)
         AG_BASE_OFF: ea_c = base_i + off_v;
         AG_IDX:      ea_c = idx_v + (index_i << shamt_i);
         AG_ABS_SET: begin
            ea_c  = imm_i;
            wbv_c = imm_i;
            upd_c = 1'b1;
         end
         AG_POST_REG: begin
            wbv_c = base_i + mod_i;
            upd_c = 1'b1;
         end
         AG_POST_IMM: begin
            wbv_c = base_i + inc_v;
            upd_c = 1'b1;
         end
         AG_BREV: begin
            ea_c  = brev_v;
            wbv_c = base_i + mod_i;
            upd_c = 1'b1;
         end
         AG_GP:       ea_c = gp_i + gp_v;
         default:     ea_c = base_i;
      endcase
   end

   assign go_c     = ~pred_en_i | (pred_i[0] ^ pred_neg_i);
   assign ea_o     = ea_c;
   assign wb_val_o = wbv_c;
   assign wb_en_o  = upd_c & go_c;
   assign cancel_o = ~go_c;

   always_comb begin
      if (cancel_o) assert (!wb_en_o) else $error("AST_CORE_CANCEL_WB"); // R9
   end
endmodule

// File: rtl/lsu_ag_top.sv
module lsu_ag_top
   import lsu_ag_pkg::*;
#(
   parameter int AW      = 32,
   parameter int PW      = 8,
   parameter int OFF_W   = 11,
   parameter int IDX_W   = 6,
   parameter int INC_W   = 4,
   parameter int GP_W    = 16,
   parameter int REV_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    mode_i,
   input  logic [1:0]    size_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] index_i,
   input  logic [AW-1:0] mod_i,
   input  logic [AW-1:0] gp_i,
   input  logic [AW-1:0] imm_i,
   input  logic [1:0]    shamt_i,
   input  logic          pred_en_i,
   input  logic          pred_neg_i,
   input  logic [PW-1:0] pred_i,
   output logic [AW-1:0] ea_o,
   output logic [AW-1:0] wb_val_o,
   output logic          wb_en_o,
   output logic          cancel_o
);
   initial begin : p_chk
      if (AW < 8) $fatal(1, "lsu_ag_top: address width too small");
   end

   logic [AW-1:0] ea_c, wbv_c;
   logic          wbe_c, cnc_c;

   lsu_ag_core #(
      .AW(AW), .PW(PW), .OFF_W(OFF_W), .IDX_W(IDX_W),
      .INC_W(INC_W), .GP_W(GP_W), .REV_W(REV_W)
   ) u_core (
      .mode_i(mode_i), .size_i(size_i), .base_i(base_i), .index_i(index_i),
      .mod_i(mod_i), .gp_i(gp_i), .imm_i(imm_i), .shamt_i(shamt_i),
      .pred_en_i(pred_en_i), .pred_neg_i(pred_neg_i), .pred_i(pred_i),
      .ea_o(ea_c), .wb_val_o(wbv_c), .wb_en_o(wbe_c), .cancel_o(cnc_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic live_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ea_o     <= '0;
               wb_val_o <= '0;
               wb_en_o  <= 1'b0;
               cancel_o <= 1'b0;
               live_q   <= 1'b0;
            end else begin
               ea_o     <= ea_c;
               wb_val_o <= wbv_c;
               wb_en_o  <= wbe_c;
               cancel_o <= cnc_c;
               live_q   <= 1'b1;
            end
         end

         AST_CANCEL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
            cancel_o |-> !wb_en_o); // R9
         AST_POSTINC_EA_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(mode_i) == 3'd3) |-> (ea_o == $past(base_i))); // R5
         AST_POSTREG_WB: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(mode_i) == 3'd3) |-> (wb_val_o == $past(base_i) + $past(mod_i))); // R5
         AST_BREV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(mode_i) == 3'd5) |-> (ea_o[AW-1:REV_W] == $past(base_i[AW-1:REV_W]))); // R7
         AST_ABS_SET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(mode_i) == 3'd2) |-> (ea_o == wb_val_o)); // R4
         AST_NO_WB_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && ($past(mode_i) == 3'd0 || $past(mode_i) == 3'd6)) |-> !wb_en_o); // R2
         AST_UNPRED_GO: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && !$past(pred_en_i)) |-> !cancel_o); // R9
      end else begin : g_comb
         assign ea_o     = ea_c;
         assign wb_val_o = wbv_c;
         assign wb_en_o  = wbe_c;
         assign cancel_o = cnc_c;
      end
   endgenerate
endmodule

// File: tb/lsu_ag_top_tb.sv
module lsu_ag_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [1:0]  size_i = '0;
   logic [31:0] base_i = '0, index_i = '0, mod_i = '0, gp_i = '0, imm_i = '0;
   logic [1:0]  shamt_i = '0;
   logic        pred_en_i = 1'b0, pred_neg_i = 1'b0;
   logic [7:0]  pred_i = '0;
   logic [31:0] ea_o, wb_val_o;
   logic        wb_en_o, cancel_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsu_ag_top u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .size_i(size_i),
      .base_i(base_i), .index_i(index_i), .mod_i(mod_i), .gp_i(gp_i),
      .imm_i(imm_i), .shamt_i(shamt_i), .pred_en_i(pred_en_i),
      .pred_neg_i(pred_neg_i), .pred_i(pred_i),
      .ea_o(ea_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o), .cancel_o(cancel_o)
   );

   function automatic logic [31:0] ext(input logic [31:0] v, input int w, input bit sg);
      logic [31:0] r;
      for (int b = 0; b < 32; b++) r[b] = (b < w) ? v[b] : (sg ? v[w-1] : 1'b0);
      return r;
   endfunction

   logic [31:0] x_ea, x_wbv;
   logic        x_wbe, x_cnc;

   task automatic model();
      logic upd;
      logic go;
      x_ea = base_i; x_wbv = base_i; upd = 1'b0;
      case (mode_i)
         3'd0: x_ea = base_i + (ext(imm_i, 11, 1) << size_i);
         3'd1: x_ea = ext(imm_i, 6, 0) + (index_i << shamt_i);
         3'd2: begin x_ea = imm_i; x_wbv = imm_i; upd = 1'b1; end
         3'd3: begin x_wbv = base_i + mod_i; upd = 1'b1; end
         3'd4: begin x_wbv = base_i + (ext(imm_i, 4, 1) << size_i); upd = 1'b1; end
         3'd5: begin
            for (int b = 0; b < 16; b++) x_ea[b] = base_i[15-b];
            x_wbv = base_i + mod_i; upd = 1'b1;
         end
         3'd6: x_ea = gp_i + (ext(imm_i, 16, 0) << size_i);
         default: x_ea = base_i;
      endcase
      go = !pred_en_i || (pred_i[0] != pred_neg_i);
      x_wbe = upd && go;
      x_cnc = !go;
   endtask

   task automatic check(input string req);
      checks++;
      if (ea_o !== x_ea || wb_val_o !== x_wbv || wb_en_o !== x_wbe || cancel_o !== x_cnc) begin
         failures++;
         $display("FAIL %s mode=%0d size=%0d: got ea=%h wbv=%h wbe=%b cnc=%b exp ea=%h wbv=%h wbe=%b cnc=%b",
                  req, mode_i, size_i, ea_o, wb_val_o, wb_en_o, cancel_o, x_ea, x_wbv, x_wbe, x_cnc);
      end
   endtask

   function automatic string req_of(input int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         6: return "R8";
         default: return "R11";
      endcase
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      // R1: reset clears outputs even with busy inputs
      mode_i = 3'd2; imm_i = 32'hDEAD_BEEF; base_i = 32'h1234_5678; pred_en_i = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (ea_o !== 0 || wb_val_o !== 0 || wb_en_o !== 0 || cancel_o !== 0) begin
         failures++;
         $display("FAIL R1 got ea=%h wbv=%h wbe=%b cnc=%b exp all zero", ea_o, wb_val_o, wb_en_o, cancel_o);
      end
      rst_n = 1'b1;
      pred_en_i = 1'b0;

      for (int m = 0; m < 8; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 6; p++) begin
               for (int q = 0; q < 4; q++) begin
                  @(negedge clk);
                  mode_i  = 3'(m);
                  size_i  = 2'(s);
                  shamt_i = 2'(p % 4);
                  // R10: p=0 forces wrap; p=1 puts sign bits at field tops
                  case (p)
                     0: begin base_i = 32'hFFFF_FFF8; mod_i = 32'h0000_0010; imm_i = 32'h0000_0007;
                              index_i = 32'hC000_0001; gp_i = 32'hFFFF_F000; end
                     1: begin base_i = 32'h0000_1000; mod_i = 32'hFFFF_FFFC; imm_i = 32'h0000_8408;
                              index_i = 32'h0000_0010; gp_i = 32'h0000_0100; end
                     default: begin
                        base_i  = 32'h9E37_79B9 * 32'(p + 7 * s + 3 * m);
                        mod_i   = 32'h7F4A_7C15 ^ (32'h0101_0101 * 32'(p));
                        imm_i   = 32'hA5C3_96E1 * 32'(p * 5 + s + 1);
                        index_i = 32'h3C6E_F372 + 32'(p * 977);
                        gp_i    = 32'hBB67_AE85 - 32'(p * 4099);
                     end
                  endcase
                  pred_en_i  = q[1] | q[0];
                  pred_neg_i = q[1];
                  pred_i     = {7'(p * 19 + m), q[0] ^ (p[0])};
                  model();
                  @(posedge clk);
                  @(negedge clk);
                  check(req_of(m));
                  if (pred_en_i) check("R9");
               end
            end
         end
      end

      // R12: outputs hold between edges after the inputs change
      @(negedge clk);
      mode_i = 3'd3; base_i = 32'h0000_4000; mod_i = 32'h40; pred_en_i = 1'b0;
      model();
      @(posedge clk);
      @(negedge clk);
      check("R12");
      base_i = 32'h7777_0000; mod_i = 32'h1;
      #1;
      check("R12");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule